// File: doc/BRIEF.md
# Memory Controller Operating-State Machine

This block is the top-level mode controller of a dynamic memory controller. Software writes a 3-bit command over a simple register bus and reads back a 2-bit status. The block holds one of four visible states: configure, ready, paused and low-power. It decides whether writes to the timing, memory and chip configuration registers may land, and whether the controller may accept new memory transactions.

Entry to and exit from low-power are delegated to an external refresh sequencer through two level request/acknowledge pairs. The status keeps showing the old state until the sequencer acknowledges. An active-pause command blocks new traffic at once, but the status shows paused only after the transactions still in flight have drained. A plain pause stops new traffic and reports paused at once. Command codes that do not fit the current state are dropped. So are the two unassigned codes and any command that arrives while a handshake or drain is pending.

Top module: `memctl_opstate`

## Requirements
- R1: After reset the status reads 0 (configure), traffic_en_o is low, and both sequencer requests are low.
- R2: A read at offset 0x00 returns the status in bits [1:0] with zeros above: configure = 0, ready = 1, paused = 2, low-power = 3. The data appears with reg_rvalid_o one cycle after the read request.
- R3: A write at offset 0x04 carries the command in bits [2:0]. Go (0) moves configure or paused to ready on the clock edge that takes the write.
- R4: Configure (4) moves ready or paused to configure on the clock edge that takes the write.
- R5: cfg_we_o is high during a write to any offset other than 0x00 or 0x04, and only while the status is configure. Such writes in any other state, and writes at 0x00 or 0x04, leave cfg_we_o low.
- R6: Sleep (1) in ready raises sr_enter_req_o and lowers traffic_en_o. The status stays ready until sr_enter_ack_i is sampled high. On that edge the status becomes low-power and the request drops.
- R7: Wakeup (2) in low-power raises sr_exit_req_o. The status stays low-power until sr_exit_ack_i is sampled high. On that edge the status becomes ready and traffic is enabled again.
- R8: Pause (3) in ready reports paused at once and lowers traffic_en_o, whatever the value of inflight_i.
- R9: Active-pause (7) in ready lowers traffic_en_o at once. The status stays ready while inflight_i is high and becomes paused on the first edge that samples inflight_i low.
- R10: Codes 5 and 6, commands that do not apply to the current state (for example go or configure in low-power, or sleep in configure), and commands that arrive during a pending handshake or drain all leave the state unchanged.
- R11: traffic_en_o is high only while the block is fully in ready: not while a sleep handshake or a drain is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register bus access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| cfg_we_o | output | 1 | Gated write enable for the configuration registers |
| traffic_en_o | output | 1 | New memory transactions may be accepted |
| inflight_i | input | 1 | Transactions are still outstanding |
| sr_enter_req_o | output | 1 | Request self-refresh entry from the sequencer |
| sr_enter_ack_i | input | 1 | Sequencer has finished self-refresh entry |
| sr_exit_req_o | output | 1 | Request self-refresh exit from the sequencer |
| sr_exit_ack_i | input | 1 | Sequencer has finished self-refresh exit |

## Verification
The handshake assertions assume a well-behaved sequencer. It must not acknowledge entry and exit together, and it raises an acknowledge only while the matching request is up. The bench drives each acknowledge as a one-cycle pulse, and only after it has seen the request at the ports. inflight_i is taken as a free level. The bench raises it before pause and active-pause and lowers it part way through a drain, so that both the immediate and the deferred route to paused are covered. Bus accesses are single-cycle strobes with at least one idle cycle between them, which is the spacing the registered read path is checked against.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

  typedef enum logic [1:0] {
    STAT_CONFIG   = 2'd0,
    STAT_READY    = 2'd1,
    STAT_PAUSED   = 2'd2,
    STAT_LOWPOWER = 2'd3
  } status_e;

  localparam int unsigned CMD_W = 3;
  localparam logic [CMD_W-1:0] OP_GO     = 3'd0;
  localparam logic [CMD_W-1:0] OP_SLEEP  = 3'd1;
  localparam logic [CMD_W-1:0] OP_WAKE   = 3'd2;
  localparam logic [CMD_W-1:0] OP_PAUSE  = 3'd3;
  localparam logic [CMD_W-1:0] OP_CONFIG = 3'd4;
  localparam logic [CMD_W-1:0] OP_APAUSE = 3'd7;

  // internal states, including the transient ones hidden from software
  typedef enum logic [2:0] {
    FS_CONFIG,
    FS_READY,
    FS_PAUSED,
    FS_LOWPOWER,
    FS_DRAIN,
    FS_SLEEP_WAIT,
    FS_WAKE_WAIT
  } fsm_e;

  typedef struct packed {
    logic go;
    logic sleep;
    logic wake;
    logic pause;
    logic config_cmd;
    logic apause;
  } cmd_t;

endpackage

// File: rtl/opstate_decode.sv
module opstate_decode
  import opstate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_OFS  = 0,
  parameter int unsigned COMMAND_OFS = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cmd_t              cmd_o,
  output logic              rd_o,
  output logic              stat_sel_o,
  output logic              other_wr_o
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(COMMAND_OFS);

  logic             hit_stat, hit_cmd, cmd_wr;
  logic [CMD_W-1:0] op;
  logic             unused_wdata;

  assign hit_stat     = (addr_i == STAT_A);
  assign hit_cmd      = (addr_i == CMD_A);
  assign cmd_wr       = req_i && we_i && hit_cmd;
  assign op           = wdata_i[CMD_W-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:CMD_W];

  assign rd_o       = req_i && !we_i;
  assign stat_sel_o = hit_stat;
  assign other_wr_o = req_i && we_i && !hit_stat && !hit_cmd;

  always_comb begin
    cmd_o = '0;
    if (cmd_wr) begin
      unique case (op)
        OP_GO:     cmd_o.go         = 1'b1;
        OP_SLEEP:  cmd_o.sleep      = 1'b1;
        OP_WAKE:   cmd_o.wake       = 1'b1;
        OP_PAUSE:  cmd_o.pause      = 1'b1;
        OP_CONFIG: cmd_o.config_cmd = 1'b1;
        OP_APAUSE: cmd_o.apause     = 1'b1;
        default:   cmd_o            = '0;  // 5 and 6: no-op
      endcase
    end
  end

endmodule

// File: rtl/opstate_fsm.sv
module opstate_fsm
  import opstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cmd_t    cmd_i,
  input  logic    inflight_i,
  input  logic    enter_ack_i,
  input  logic    exit_ack_i,
  output status_e status_o,
  output logic    traffic_en_o,
  output logic    enter_req_o,
  output logic    exit_req_o
);

  fsm_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_CONFIG:   if (cmd_i.go) st_d = FS_READY;
      FS_READY: begin
        if (cmd_i.sleep)           st_d = FS_SLEEP_WAIT;
        else if (cmd_i.pause)      st_d = FS_PAUSED;
        else if (cmd_i.apause)     st_d = FS_DRAIN;
        else if (cmd_i.config_cmd) st_d = FS_CONFIG;
      end
      FS_PAUSED: begin
        if (cmd_i.go)              st_d = FS_READY;
        else if (cmd_i.config_cmd) st_d = FS_CONFIG;
      end
      FS_DRAIN:      if (!inflight_i) st_d = FS_PAUSED;
      FS_SLEEP_WAIT: if (enter_ack_i) st_d = FS_LOWPOWER;
      FS_LOWPOWER:   if (cmd_i.wake)  st_d = FS_WAKE_WAIT;
      FS_WAKE_WAIT:  if (exit_ack_i)  st_d = FS_READY;
      default:       st_d = FS_CONFIG;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FS_CONFIG;
    else         st_q <= st_d;
  end

  // transient states report the state software last saw settle
  always_comb begin
    unique case (st_q)
      FS_CONFIG:                         status_o = STAT_CONFIG;
      FS_READY, FS_DRAIN, FS_SLEEP_WAIT: status_o = STAT_READY;
      FS_PAUSED:                         status_o = STAT_PAUSED;
      FS_LOWPOWER, FS_WAKE_WAIT:         status_o = STAT_LOWPOWER;
      default:                           status_o = STAT_CONFIG;
    endcase
  end

  assign traffic_en_o = (st_q == FS_READY);
  assign enter_req_o  = (st_q == FS_SLEEP_WAIT);
  assign exit_req_o   = (st_q == FS_WAKE_WAIT);

endmodule

// File: rtl/opstate_regif.sv
module opstate_regif
  import opstate_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              stat_sel_i,
  input  logic              other_wr_i,
  input  status_e           status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              cfg_we_o
);

  localparam int unsigned STAT_W = $bits(status_e);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) begin
        rdata_o <= stat_sel_i ? {{(DATA_W-STAT_W){1'b0}}, status_i} : '0;
      end
    end
  end

  assign cfg_we_o = other_wr_i && (status_i == STAT_CONFIG);

endmodule

// File: rtl/memctl_opstate.sv
module memctl_opstate
  import opstate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_OFS  = 0,
  parameter int unsigned COMMAND_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              cfg_we_o,
  output logic              traffic_en_o,
  input  logic              inflight_i,
  output logic              sr_enter_req_o,
  input  logic              sr_enter_ack_i,
  output logic              sr_exit_req_o,
  input  logic              sr_exit_ack_i
);

  cmd_t    cmd;
  logic    rd, stat_sel, other_wr;
  status_e status;

  opstate_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_OFS(STATUS_OFS), .COMMAND_OFS(COMMAND_OFS)
  ) i_decode (
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cmd_o(cmd), .rd_o(rd), .stat_sel_o(stat_sel), .other_wr_o(other_wr)
  );

  opstate_fsm i_fsm (
    .clk_i, .rst_ni, .cmd_i(cmd), .inflight_i,
    .enter_ack_i(sr_enter_ack_i), .exit_ack_i(sr_exit_ack_i),
    .status_o(status), .traffic_en_o,
    .enter_req_o(sr_enter_req_o), .exit_req_o(sr_exit_req_o)
  );

  opstate_regif #(.DATA_W(DATA_W)) i_regif (
    .clk_i, .rst_ni, .rd_i(rd), .stat_sel_i(stat_sel), .other_wr_i(other_wr),
    .status_i(status), .rdata_o(reg_rdata_o), .rvalid_o(reg_rvalid_o),
    .cfg_we_o
  );

endmodule

// File: rtl/opstate_checker.sv
module opstate_checker
  import opstate_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input status_e status_i,
  input logic    cfg_we_i,
  input logic    traffic_en_i,
  input logic    enter_req_i,
  input logic    enter_ack_i,
  input logic    exit_req_i,
  input logic    exit_ack_i
);

  assert_cfg_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> status_i == STAT_CONFIG);

  assert_lowpower_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == STAT_LOWPOWER && $past(status_i) == STAT_READY) |-> $past(enter_ack_i));

  assert_enter_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_req_i && !enter_ack_i) |=> enter_req_i);

  assert_ready_after_exit_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == STAT_READY && $past(status_i) == STAT_LOWPOWER) |-> $past(exit_ack_i));

  assert_exit_req_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_req_i && !exit_ack_i) |=> exit_req_i);

  assert_traffic_only_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    traffic_en_i |-> (status_i == STAT_READY && !enter_req_i && !exit_req_i));

  assert_one_request_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enter_req_i && exit_req_i));

endmodule

bind memctl_opstate opstate_checker i_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status), .cfg_we_i(cfg_we_o),
  .traffic_en_i(traffic_en_o), .enter_req_i(sr_enter_req_o), .enter_ack_i(sr_enter_ack_i),
  .exit_req_i(sr_exit_req_o), .exit_ack_i(sr_exit_ack_i)
);

// File: tb/test_memctl_opstate.sv
`timescale 1ns/1ps
module test_memctl_opstate;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid, cfg_we, traffic, inflight = 1'b0;
  logic              ent_req, ent_ack = 1'b0, ext_req, ext_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [DATA_W-1:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  memctl_opstate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_memctl_opstate (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid), .cfg_we_o(cfg_we),
    .traffic_en_o(traffic), .inflight_i(inflight), .sr_enter_req_o(ent_req),
    .sr_enter_ack_i(ent_ack), .sr_exit_req_o(ext_req), .sr_exit_ack_i(ext_ack)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data as it comes back
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=%0h expected=none", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rdata, e.val);
      end
    end
  end

  task automatic read_status(input logic [1:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 12'h000;
    exp_q.push_back('{val: {30'd0, exp}, tag: tag});
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic exp_we, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 check(tag, {31'd0, cfg_we}, {31'd0, exp_we});
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic command(input logic [2:0] op);
    write_reg(12'h004, {29'h1555_5555, op}, 1'b0, "R5 cmd-offset");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 traffic", {31'd0, traffic}, 32'd0);
    check("R1 reqs", {30'd0, ent_req, ext_req}, 32'd0);
    read_status(2'd0, "R1 R2 reset status");

    // R5 configuration writes in configure
    write_reg(12'h010, 32'h1234, 1'b1, "R5 cfg in configure");
    write_reg(12'h000, 32'h0, 1'b0, "R5 status offset");

    // R10 no-op codes and sleep in configure
    command(3'd5); read_status(2'd0, "R10 code5");
    command(3'd1); read_status(2'd0, "R10 sleep in cfg");

    // R3 go
    command(3'd0);
    check("R11 traffic ready", {31'd0, traffic}, 32'd1);
    read_status(2'd1, "R3 go");
    write_reg(12'h02c, 32'h7, 1'b0, "R5 cfg in ready");
    command(3'd6); read_status(2'd1, "R10 code6");

    // R8 pause with traffic outstanding
    inflight = 1'b1;
    command(3'd3);
    check("R8 traffic", {31'd0, traffic}, 32'd0);
    read_status(2'd2, "R8 pause");
    write_reg(12'h200, 32'h1, 1'b0, "R5 cfg in paused");
    command(3'd0); read_status(2'd1, "R3 go from paused");

    // R9 active pause drains
    command(3'd7);
    check("R9 traffic", {31'd0, traffic}, 32'd0);
    read_status(2'd1, "R9 drain");
    command(3'd4); read_status(2'd1, "R10 cfg during drain");
    @(negedge clk) inflight = 1'b0;
    @(negedge clk);
    read_status(2'd2, "R9 drained");

    // R4 configure from paused
    command(3'd4); read_status(2'd0, "R4 cfg from paused");
    command(3'd0); read_status(2'd1, "R3 go again");

    // R6 sleep handshake
    command(3'd1);
    check("R6 enter req", {31'd0, ent_req}, 32'd1);
    check("R11 traffic in sleep wait", {31'd0, traffic}, 32'd0);
    read_status(2'd1, "R6 waiting");
    command(3'd3); read_status(2'd1, "R10 pause during sleep wait");
    @(negedge clk) ent_ack = 1'b1;
    @(negedge clk) ent_ack = 1'b0;
    check("R6 req dropped", {31'd0, ent_req}, 32'd0);
    read_status(2'd3, "R6 low-power");

    // R10 invalid in low-power
    command(3'd0); read_status(2'd3, "R10 go in low-power");
    command(3'd4); read_status(2'd3, "R10 cfg in low-power");

    // R7 wake handshake
    command(3'd2);
    check("R7 exit req", {31'd0, ext_req}, 32'd1);
    read_status(2'd3, "R7 waiting");
    @(negedge clk) ext_ack = 1'b1;
    @(negedge clk) ext_ack = 1'b0;
    check("R7 traffic", {31'd0, traffic}, 32'd1);
    check("R7 req dropped", {31'd0, ext_req}, 32'd0);
    read_status(2'd1, "R7 ready");

    // R4 configure from ready
    command(3'd4); read_status(2'd0, "R4 cfg from ready");
    write_reg(12'h030, 32'h5, 1'b1, "R5 cfg reopened");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 actual=%0d expected=0 pending reads", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule